// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers sixteen interrupt sources into one pending register and gives the CPU a single request line. Eight sources are external request pins. The pins are active-low and asynchronous, so each one passes through a synchronizer. The other eight are active-high level signals from on-chip units such as a timer. The external pins and the internal levels are interleaved in one fixed priority order.

A mask register enables each source on its own. A mode register chooses, for each external pin, one of two behaviours:

- Level mode: the pending bit tracks the pin.
- Edge mode: a falling edge latches the pending bit until software clears it.

The vector register reports an even code for the highest-priority source that is both pending and enabled. An interrupt handler can use that code directly as an offset into a jump table.

Software reaches four registers over a plain register bus. Each register is selected by a 2-bit select code. A write lands on the rising clock edge while the write enable is high. Read data is combinational from the select code.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask, the mode register and every pending bit, and holds `irq_o` low. Select codes are 0 pending, 1 mask, 2 mode, 3 vector. After reset, the vector register (select 3) reads 0x20000000.
- R2: In level mode, pending bit 2k equals the inverse of pin k, three rising edges after the pin changes. Pending bit 2k+1 equals internal level k one edge after it changes.
- R3: Source index i is the pending and mask bit position i. Even index 2k is external pin k and odd index 2k+1 is internal level k. A lower index has higher priority.
- R4: `irq_o` is high exactly when some bit is 1 in both the pending and the mask registers.
- R5: The vector register holds, in bits 31:24, twice the lowest index that is both pending and unmasked. It holds 0x20 when no such index exists. Bits 23:0 read zero.
- R6: With mode bit k set to 1 (edge mode), a falling edge on pin k sets pending bit 2k three edges later. The bit stays set after the pin returns high.
- R7: Writing the pending register clears each edge-mode pending bit whose data bit is 1 and leaves bits written with 0 alone. Such a write has no effect on level-mode or internal bits.
- R8: A falling edge that reaches the pending logic in the same cycle as a clear of that bit leaves the bit set.
- R9: A pin held low after its edge-mode bit is cleared does not set the bit again.
- R10: Mask reads back bits 15:0 and mode reads back bits 7:0 as written, with higher bits reading zero. Writes to the vector register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_pin_n_i | input | 8 | External active-low request pins, asynchronous |
| int_lvl_i | input | 8 | Internal active-high request levels, synchronous |
| bus_we_i | input | 1 | Register write enable |
| bus_sel_i | input | 2 | Register select (0 pending, 1 mask, 2 mode, 3 vector) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench goes after the priority interleave by placing competing external and internal sources on adjacent indices. An encoder that swapped the two groups would return the neighbour's code. It also masks the winner so the next source must take over.

In edge mode, the bench checks three things:
- A latched bit survives the pin going high.
- A stray clear of a level bit does nothing.
- A clear with a 0 data bit does nothing.

A design that cleared every bit on any pending write, or followed the pin in edge mode, would show a lost or phantom bit.

A falling edge is timed to meet a clear in the same cycle, and a pin is held low after a clear. Giving the clear priority, or re-arming on a low level, would then show as a dropped or repeated request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W   = 32;
    localparam int CODE_W   = 8;
    localparam int CODE_LSB = DATA_W - CODE_W;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_MODE = 2'd2,
        SEL_VEC  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Place a source code in the top byte of a bus word.
    function automatic logic [DATA_W-1:0] pack_vec(input logic [CODE_W-1:0] code);
        return {code, {CODE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N_PIN  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_PIN-1:0] pin_n_i,
    output logic [N_PIN-1:0] active_o,
    output logic [N_PIN-1:0] fall_o
);

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        // STAGES synchronizer flops plus one history flop for edge detection
        logic [STAGES:0] shreg;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shreg <= '1;
            end else begin
                shreg <= {shreg[STAGES-1:0], pin_n_i[g]};
            end
        end

        assign active_o[g] = ~shreg[STAGES-1];
        assign fall_o[g]   = shreg[STAGES] & ~shreg[STAGES-1];
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int N_PIN = 8,
    localparam int N_SRC = 2 * N_PIN
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_PIN-1:0] active_i,
    input  logic [N_PIN-1:0] fall_i,
    input  logic [N_PIN-1:0] int_lvl_i,
    input  logic [N_PIN-1:0] edge_mode_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_bits_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] pend_q;

    for (genvar k = 0; k < N_PIN; k++) begin : g_src
        // external pin k -> even index
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pend_q[2*k] <= 1'b0;
            end else if (edge_mode_i[k]) begin
                // a new edge wins over a clear in the same cycle
                pend_q[2*k] <= fall_i[k] | (pend_q[2*k] & ~(clr_we_i & clr_bits_i[2*k]));
            end else begin
                pend_q[2*k] <= active_i[k];
            end
        end

        // internal level k -> odd index
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pend_q[2*k+1] <= 1'b0;
            end else begin
                pend_q[2*k+1] <= int_lvl_i[k];
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]  req_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);

    logic [IDX_W-1:0] idx;

    // Scan from lowest priority up so the lowest set index is left standing.
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any_o  = |req_i;
    assign code_o = any_o ? (CODE_W'(idx) << 1) : CODE_W'(2 * N_SRC);

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_PIN = 8,
    localparam int N_SRC = 2 * N_PIN
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_req_t          req_i,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_PIN-1:0]  mode_o,
    output logic              clr_we_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [N_SRC-1:0] mask_q;
    logic [N_PIN-1:0] mode_q;
    logic             unused_hi;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (req_i.we) begin
            case (req_i.sel)
                SEL_MASK: mask_q <= req_i.wdata[N_SRC-1:0];
                SEL_MODE: mode_q <= req_i.wdata[N_PIN-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (req_i.sel)
            SEL_PEND: rdata_o[N_SRC-1:0] = pend_i;
            SEL_MASK: rdata_o[N_SRC-1:0] = mask_q;
            SEL_MODE: rdata_o[N_PIN-1:0] = mode_q;
            default:  rdata_o            = pack_vec(code_i);
        endcase
    end

    assign clr_we_o  = req_i.we && (req_i.sel == SEL_PEND);
    assign mask_o    = mask_q;
    assign mode_o    = mode_q;
    assign unused_hi = ^req_i.wdata[DATA_W-1:N_SRC];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_PIN       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_PIN-1:0]  irq_pin_n_i,
    input  logic [N_PIN-1:0]  int_lvl_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_sel_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam int N_SRC = 2 * N_PIN;

    bus_req_t          req;
    logic [N_PIN-1:0]  pin_active;
    logic [N_PIN-1:0]  pin_fall;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  mask_q;
    logic [N_PIN-1:0]  mode_q;
    logic              clr_we;
    logic              any_req;
    logic [CODE_W-1:0] vec_code;

    assign req.we    = bus_we_i;
    assign req.sel   = reg_sel_e'(bus_sel_i);
    assign req.wdata = bus_wdata_i;

    irqc_sync #(.N_PIN(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pin_n_i  (irq_pin_n_i),
        .active_o (pin_active),
        .fall_o   (pin_fall)
    );

    irqc_pending #(.N_PIN(N_PIN)) u_pend (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .active_i    (pin_active),
        .fall_i      (pin_fall),
        .int_lvl_i   (int_lvl_i),
        .edge_mode_i (mode_q),
        .clr_we_i    (clr_we),
        .clr_bits_i  (bus_wdata_i[N_SRC-1:0]),
        .pend_o      (pend)
    );

    irqc_prio #(.N_SRC(N_SRC)) u_prio (
        .req_i  (pend & mask_q),
        .any_o  (any_req),
        .code_o (vec_code)
    );

    irqc_regs #(.N_PIN(N_PIN)) u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .req_i    (req),
        .pend_i   (pend),
        .code_i   (vec_code),
        .mask_o   (mask_q),
        .mode_o   (mode_q),
        .clr_we_o (clr_we),
        .rdata_o  (bus_rdata_o)
    );

    assign irq_o = any_req;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_PIN = 8,
    localparam int N_SRC = 2 * N_PIN
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             irq_o,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] mask,
    input logic [N_PIN-1:0] mode,
    input logic [7:0]       code,
    input logic             bus_we,
    input logic [1:0]       bus_sel
);

    localparam logic [7:0] NONE = 8'(2 * N_SRC);

    logic [N_PIN-1:0] latched;
    always_comb begin
        for (int k = 0; k < N_PIN; k++) begin
            latched[k] = pend[2*k] & mode[k];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (mask == '0 && mode == '0 && !irq_o));

    // R4
    irq_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o == (code != NONE));

    // R5
    code_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (code[0] == 1'b0) && (code <= NONE));

    // R6
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_we && (bus_sel == 2'd0 || bus_sel == 2'd2)) |=> (($past(latched) & ~latched) == '0));

    // R10
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_we && bus_sel == 2'd1) |=> $stable(mask));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_PIN(N_PIN)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .irq_o   (irq_o),
    .pend    (pend),
    .mask    (mask_q),
    .mode    (mode_q),
    .code    (vec_code),
    .bus_we  (bus_we_i),
    .bus_sel (bus_sel_i)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_n = 8'hFF;
    logic [7:0]  lvl = 8'h00;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk_i       (clk),
        .rst_i       (rst),
        .irq_pin_n_i (pin_n),
        .int_lvl_i   (lvl),
        .bus_we_i    (we),
        .bus_sel_i   (sel),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {pins_n, levels, mask, expected pending, expected code}
    localparam logic [55:0] VECS [10] = '{
        {8'hFF, 8'h00, 16'hFFFF, 16'h0000, 8'h20},
        {8'hFE, 8'h01, 16'hFFFF, 16'h0003, 8'h00},
        {8'hFE, 8'h01, 16'hFFFE, 16'h0003, 8'h02},
        {8'h7F, 8'h80, 16'hFFFF, 16'hC000, 8'h1C},
        {8'h7F, 8'h80, 16'h8000, 16'hC000, 8'h1E},
        {8'hFD, 8'h01, 16'hFFFF, 16'h0006, 8'h02},
        {8'hFD, 8'h01, 16'h0000, 16'h0006, 8'h20},
        {8'hFF, 8'h10, 16'h0200, 16'h0200, 8'h12},
        {8'hEF, 8'h10, 16'h0300, 16'h0300, 8'h10},
        {8'h00, 8'hFF, 16'hAAAA, 16'hFFFF, 8'h02}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
        we = 1'b1; sel = s; wdata = d;
        step(1);
        we = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [31:0] d);
        sel = s;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin : watchdog
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        bus_rd(2'd0, d); chk("R1 pending", d, 32'h0);
        bus_rd(2'd1, d); chk("R1 mask", d, 32'h0);
        bus_rd(2'd2, d); chk("R1 mode", d, 32'h0);
        bus_rd(2'd3, d); chk("R1 vector", d, 32'h2000_0000);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4 R5 table walk, all pins in level mode
        for (int i = 0; i < 10; i++) begin
            logic [55:0] v;
            v = VECS[i];
            bus_wr(2'd1, {16'h0, v[39:24]});
            pin_n = v[55:48];
            lvl   = v[47:40];
            step(4);
            bus_rd(2'd0, d); chk($sformatf("R2 R3 pending vec%0d", i), d, {16'h0, v[23:8]});
            bus_rd(2'd3, d); chk($sformatf("R5 code vec%0d", i), d, {v[7:0], 24'h0});
            chk($sformatf("R4 irq vec%0d", i), {31'b0, irq}, {31'b0, v[7:0] != 8'h20});
        end

        pin_n = 8'hFF; lvl = 8'h00;
        step(4);

        // R10 register widths and a write to the vector register
        bus_wr(2'd1, 32'hFFFF_FFFF);
        bus_rd(2'd1, d); chk("R10 mask width", d, 32'h0000_FFFF);
        bus_wr(2'd2, 32'hFFFF_FFFF);
        bus_rd(2'd2, d); chk("R10 mode width", d, 32'h0000_00FF);
        bus_wr(2'd2, 32'h0000_0008);
        bus_wr(2'd3, 32'h1234_5678);
        bus_rd(2'd3, d); chk("R10 vector write ignored", d, 32'h2000_0000);
        bus_rd(2'd1, d); chk("R10 mask after vector write", d, 32'h0000_FFFF);

        // R6 edge latch on pin 3 (index 6)
        pin_n = 8'hF7; step(2);
        pin_n = 8'hFF; step(4);
        bus_rd(2'd0, d); chk("R6 latched pending", d, 32'h0000_0040);
        bus_rd(2'd3, d); chk("R6 code", d, 32'h0C00_0000);
        chk("R6 irq", {31'b0, irq}, 32'h1);

        // R7 clear semantics
        bus_wr(2'd0, 32'h0000_FFBF);
        bus_rd(2'd0, d); chk("R7 zero bit keeps latch", d, 32'h0000_0040);
        pin_n = 8'hFE; step(4);
        bus_wr(2'd0, 32'h0000_0001);
        bus_rd(2'd0, d); chk("R7 level bit unaffected", d, 32'h0000_0041);
        bus_wr(2'd0, 32'h0000_0040);
        bus_rd(2'd0, d); chk("R7 edge bit cleared", d, 32'h0000_0001);

        // R9 pin held low after clear does not re-latch
        pin_n = 8'hF6; step(4);
        bus_rd(2'd0, d); chk("R9 latch before clear", d, 32'h0000_0041);
        bus_wr(2'd0, 32'h0000_0040);
        step(5);
        bus_rd(2'd0, d); chk("R9 stays clear while low", d, 32'h0000_0001);

        // R8 edge meeting a clear in the same cycle
        pin_n = 8'hFE; step(4);
        pin_n = 8'hF6; step(2);
        bus_wr(2'd0, 32'h0000_0040);
        bus_rd(2'd0, d); chk("R8 set wins over clear", d, 32'h0000_0041);

        // R1 reset during operation
        rst = 1'b1; step(1);
        rst = 1'b0; step(1);
        bus_rd(2'd1, d); chk("R1 mask after reset", d, 32'h0);
        bus_rd(2'd2, d); chk("R1 mode after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule